// File: doc/BRIEF.md
# Edge Interrupt and Overload Status Unit

This block sits beside a serial control port. It holds an 18-bit control register: twelve general-purpose output bits, five interrupt enables and one pin-function select. It watches four asynchronous general-purpose inputs and five synchronous overload indicators. Each enabled source raises a sticky interrupt flag when its input changes in either direction. For the fifth source, the input is any change of the overload vector. Overload indicators are also latched into sticky overload flags.

The unit builds a 32-bit status word for the serial port to shift out. The word holds a version constant, the synchronized inputs, the interrupt flags and the overload flags. The serial port signals the end of each word with a one-cycle strobe. That strobe clears every interrupt and overload flag, except that an event arriving in the same cycle wins over the clear. A single shared output pin shows one of two things, chosen by the select bit: the interrupt request, or an active-low summary of the overload flags.

Top module: `eisu_status_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the control register, all interrupt flags and all overload flags clear. So gp_out = 0, irq = 0, shared_pin = 1, and status_word holds only the version constant.
- R2: A cycle with ctrl_wr high loads ctrl_data[11:0] into gp_out, ctrl_data[16:12] into the enables and ctrl_data[17] into the select. Enable bit 12+i belongs to gp_in[i], and bit 16 belongs to the overload source. ctrl_data[25:18] has no effect, and without ctrl_wr the register holds its value.
- R3: gp_in passes through two flip-flops. status_word[11:8] shows gp_in as it was two edges earlier. A rise or fall of gp_in[i] with its enable set makes status_word[12+i] read 1 after the third edge from the change.
- R4: A source whose enable is low never sets its flag. Setting the enable later does not report changes that happened while it was low.
- R5: ovl_in[i] high at a clock edge sets overload flag status_word[20+i]. The flag stays set until a read strobe clears it.
- R6: With enable bit 16 set, any edge at which ovl_in differs from its value at the previous edge sets status_word[16].
- R7: rd_done high at an edge clears all interrupt and overload flags. A flag whose set condition holds at the same edge stays set.
- R8: status_word[7:0] equals the VERSION parameter, and bits 19:17 and 31:25 read 0.
- R9: irq is the OR of the five interrupt flags. shared_pin equals irq when the select is 1, and equals the NOR of the overload flags when it is 0.
- R10: After reset, edge detection stays off for the first three edges. As a result, gp_in levels held through reset raise no interrupt, even when the enables are written in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 26 | Data field from the serial port |
| gp_in | input | 4 | Asynchronous general-purpose inputs |
| ovl_in | input | 5 | Synchronous overload indicators |
| rd_done | input | 1 | End-of-word strobe of a status read |
| gp_out | output | 12 | General-purpose output bits |
| status_word | output | 32 | Assembled status word |
| irq | output | 1 | Interrupt request |
| shared_pin | output | 1 | Interrupt or active-low overload summary |

## Verification
The hardest case to reach is the startup window. Inputs that sit high through reset must stay silent even though the synchronizer stages start from zero. The bench holds every gp_in high during reset and writes all enables at the first edge after release. It then confirms that no flag appears. A second hard case is a clear that coincides with a new event. The bench makes this happen by asserting rd_done in the same cycle as an overload level or an overload vector change. Long stretches of random stimulus are then compared against a behavioural reference model on every clock.

// File: rtl/eisu_pkg.sv
// Package: shared widths, field positions and the control register type
// for the edge interrupt and overload status unit.
package eisu_pkg;
    localparam int GPO_W    = 12;          // general-purpose output bits
    localparam int GPI_N    = 4;           // general-purpose inputs
    localparam int OVL_N    = 5;           // overload indicators
    localparam int SRC_N    = GPI_N + 1;   // interrupt sources
    localparam int CTL_W    = 26;          // serial data field width
    localparam int WORD_W   = 32;          // status word width
    localparam int VER_W    = 8;           // version field width
    localparam int ST_GPI   = VER_W;       // status: synced inputs
    localparam int ST_IRQ   = ST_GPI + GPI_N;  // status: interrupt flags
    localparam int ST_OVL   = 20;          // status: overload flags
    localparam int CTL_USED = GPO_W + SRC_N + 1;

    // Control register, packed so that it lines up with data bits 17:0.
    typedef struct packed {
        logic             sel;
        logic [SRC_N-1:0] en;
        logic [GPO_W-1:0] gpo;
    } ctl_t;
endpackage

// File: rtl/eisu_ctrl_reg.sv
// Module: eisu_ctrl_reg
// Holds the control register (outputs, enables, pin select). It loads
// from the low bits of the data field on a write strobe. Assumes the
// strobe is a single-cycle pulse from the serial port. Upper field bits
// are not stored.
module eisu_ctrl_reg
    import eisu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_USED-1:0] data,
    output ctl_t             ctl
);
    // Register load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl <= '0;
        else if (wr) ctl <= ctl_t'(data);
    end

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctl));
endmodule

// File: rtl/eisu_gp_edge.sv
// Module: eisu_gp_edge
// Synchronizes asynchronous inputs through a chain of STAGES flip-flops
// and flags any level change of the synchronized value. Detection is
// held off until the chain and the previous-value register carry real
// samples taken after reset. Assumes the inputs change slower than the
// clock.
module eisu_gp_edge #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_val,
    output logic [N-1:0] edge_out
);
    localparam int ARM   = STAGES + 1;
    localparam int CNT_W = $clog2(ARM + 1);

    logic [N-1:0]     stage [STAGES];
    logic [N-1:0]     prev;
    logic [CNT_W-1:0] arm_cnt;
    logic             armed;

    // Synchronizer chain, first stage samples the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage[k] <= '0;
        end else begin
            stage[0] <= async_in;
            for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
        end
    end

    assign sync_val = stage[STAGES-1];

    // Previous-value register for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sync_val;
    end

    // Startup counter that arms detection once the pipeline is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)        arm_cnt <= '0;
        else if (!armed)   arm_cnt <= arm_cnt + 1'b1;
    end

    assign armed = (arm_cnt == CNT_W'(ARM));

    // Per-bit change detection, gated by the arm state.
    for (genvar i = 0; i < N; i++) begin : g_det
        assign edge_out[i] = armed & (sync_val[i] ^ prev[i]);
    end
endmodule

// File: rtl/eisu_ovl_latch.sv
// Module: eisu_ovl_latch
// Latches overload indicators into sticky flags that clear on a read
// strobe, with a set taking priority over the clear. It also reports
// any change of the indicator vector since the previous cycle. Assumes
// the indicators are already synchronous to clk.
module eisu_ovl_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ovl_in,
    input  logic         clr,
    output logic [N-1:0] flags,
    output logic         change
);
    logic [N-1:0] last;

    // Sticky flags: set wins over clear.
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (ovl_in[i]) flags[i] <= 1'b1;
            else if (clr)       flags[i] <= 1'b0;
        end

        // R5
        ovl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovl_in[i] |=> flags[i]);
        // R7
        ovl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !ovl_in[i]) |=> !flags[i]);
    end

    // Previous indicator vector for change reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= '0;
        else        last <= ovl_in;
    end

    assign change = |(ovl_in ^ last);
endmodule

// File: rtl/eisu_irq_flags.sv
// Module: eisu_irq_flags
// One sticky flag per interrupt source. An enabled event sets it and a
// read strobe clears it, and an event at the clearing edge survives.
// The request output is the OR of the flags. Assumes events are
// single-cycle indications.
module eisu_irq_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags,
    output logic         req
);
    // Per-source flag: enabled event sets, strobe clears.
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)                 flags[i] <= 1'b0;
            else if (en[i] && evt[i])   flags[i] <= 1'b1;
            else if (clr)               flags[i] <= 1'b0;
        end

        // R7
        irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr) |=> flags[i]);
    end

    assign req = |flags;
endmodule

// File: rtl/eisu_status_unit.sv
// Module: eisu_status_unit (top)
// Collects general-purpose inputs and overload indicators, raises
// change-triggered interrupts under the control register enables, and
// assembles the status word for the serial port. The read strobe clears
// flags at the same edge that the serial port captures the word. Assumes
// rd_done is the port's one-cycle end-of-word pulse.
module eisu_status_unit
    import eisu_pkg::*;
#(
    parameter logic [7:0] VERSION     = 8'h5A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTL_W-1:0]  ctrl_data,
    input  logic [GPI_N-1:0]  gp_in,
    input  logic [OVL_N-1:0]  ovl_in,
    input  logic              rd_done,
    output logic [GPO_W-1:0]  gp_out,
    output logic [WORD_W-1:0] status_word,
    output logic              irq,
    output logic              shared_pin
);
    ctl_t             ctl;
    logic [GPI_N-1:0] gp_sync;
    logic [GPI_N-1:0] gp_edge;
    logic [OVL_N-1:0] ovl_flags;
    logic             ovl_change;
    logic [SRC_N-1:0] irq_flags;
    logic             unused_hi;

    assign unused_hi = ^ctrl_data[CTL_W-1:CTL_USED];

    eisu_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .data  (ctrl_data[CTL_USED-1:0]),
        .ctl   (ctl)
    );

    eisu_gp_edge #(.N(GPI_N), .STAGES(SYNC_STAGES)) u_gp (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gp_in),
        .sync_val (gp_sync),
        .edge_out (gp_edge)
    );

    eisu_ovl_latch #(.N(OVL_N)) u_ovl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovl_in (ovl_in),
        .clr    (rd_done),
        .flags  (ovl_flags),
        .change (ovl_change)
    );

    eisu_irq_flags #(.N(SRC_N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctl.en),
        .evt   ({ovl_change, gp_edge}),
        .clr   (rd_done),
        .flags (irq_flags),
        .req   (irq)
    );

    // Status word assembly, unused fields tied to zero.
    always_comb begin
        status_word                             = '0;
        status_word[VER_W-1:0]                  = VERSION;
        status_word[ST_GPI +: GPI_N]            = gp_sync;
        status_word[ST_IRQ +: SRC_N]            = irq_flags;
        status_word[ST_OVL +: OVL_N]            = ovl_flags;
    end

    // Shared pin function select.
    assign shared_pin = ctl.sel ? irq : ~|ovl_flags;
    assign gp_out     = ctl.gpo;

    // R4: a disabled source with a clear flag stays clear.
    for (genvar i = 0; i < SRC_N; i++) begin : g_dis
        dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl.en[i] && !irq_flags[i]) |=> !irq_flags[i]);
    end
endmodule

// File: tb/eisu_status_unit_test.sv
`timescale 1ns/1ps
module eisu_status_unit_test;
    localparam logic [7:0] VER = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [25:0] ctrl_data = '0;
    logic [3:0]  gp_in = '0;
    logic [4:0]  ovl_in = '0;
    logic        rd_done = 1'b0;
    logic [11:0] gp_out;
    logic [31:0] status_word;
    logic        irq, shared_pin;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    eisu_status_unit #(.VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .gp_in(gp_in), .ovl_in(ovl_in), .rd_done(rd_done), .gp_out(gp_out),
        .status_word(status_word), .irq(irq), .shared_pin(shared_pin));

    // Reference model state (behavioural)
    int unsigned m_s1, m_s2, m_prev, m_oprev, m_irqf, m_ovlf, m_cyc;
    int unsigned m_gpo, m_en, m_sel;

    always @(posedge clk) begin
        int unsigned ev;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_oprev = 0; m_irqf = 0;
            m_ovlf = 0; m_cyc = 0; m_gpo = 0; m_en = 0; m_sel = 0;
        end else begin
            ev = (m_cyc >= 3) ? (m_s2 ^ m_prev) : 0;
            if (ovl_in != m_oprev[4:0]) ev = ev | 16;
            if (rd_done) begin m_irqf = 0; m_ovlf = 0; end
            m_irqf = m_irqf | (ev & m_en);
            m_ovlf = m_ovlf | ovl_in;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = gp_in; m_oprev = ovl_in;
            if (ctrl_wr) begin
                m_gpo = ctrl_data[11:0]; m_en = ctrl_data[16:12];
                m_sel = ctrl_data[17];
            end
            if (m_cyc < 10) m_cyc++;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 gp_out", gp_out, m_gpo);
            chk("R3 synced inputs", status_word[11:8], m_s2);
            chk("R7 irq flags", status_word[16:12], m_irqf);
            chk("R5 ovl flags", status_word[24:20], m_ovlf);
            chk("R8 fixed fields", {status_word[31:25], status_word[19:17], status_word[7:0]}, {10'd0, VER});
            chk("R9 irq", irq, m_irqf != 0);
            chk("R9 pin", shared_pin, m_sel ? (m_irqf != 0) : (m_ovlf == 0));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [25:0] d);
        ctrl_wr = 1; ctrl_data = d; tick(1); ctrl_wr = 0;
    endtask

    task automatic rd();
        rd_done = 1; tick(1); rd_done = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        gp_in = 4'hF;
        tick(4);
        // R1 reset state
        chk("R1 gp_out", gp_out, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin", shared_pin, 1);
        chk("R1 status", status_word, {24'd0, VER});
        rst_n = 1;
        // R10 enables written at first edge, inputs held high
        wr_ctl({8'hFF, 1'b0, 5'h1F, 12'hABC});
        tick(8);
        chk("R10 no startup irq", status_word[16:12], 0);
        chk("R2 upper bits ignored", gp_out, 12'hABC);
        // R3 falling edge on gp_in[1]
        gp_in[1] = 0;
        tick(1);
        chk("R3 not yet", status_word[13], 0);
        tick(2);
        chk("R3 flag after third edge", status_word[13], 1);
        chk("R3 synced value", status_word[11:8], 4'hD);
        rd();
        chk("R7 cleared", status_word[16:12], 0);
        // R4 disabled source, then enable
        wr_ctl({8'h0, 1'b0, 5'h1E, 12'h123});
        gp_in[0] = 0;
        tick(5);
        chk("R4 disabled", status_word[12], 0);
        wr_ctl({8'h0, 1'b0, 5'h1F, 12'h123});
        tick(4);
        chk("R4 no retro", status_word[12], 0);
        // R5 R6 overload pulse
        ovl_in = 5'b00100; tick(1); ovl_in = 0; tick(1);
        chk("R5 ovl latched", status_word[22], 1);
        chk("R6 ovl irq", status_word[16], 1);
        chk("R9 pin low", shared_pin, 0);
        wr_ctl({8'h0, 1'b1, 5'h1F, 12'h123});
        chk("R9 pin irq", shared_pin, 1);
        // R7 clear coincident with set: ovl held and changing
        ovl_in = 5'b00001; rd_done = 1; tick(1); rd_done = 0;
        chk("R7 ovl set wins", status_word[24:20], 5'b00001);
        chk("R7 irq set wins", status_word[16], 1);
        ovl_in = 0; tick(1); rd(); tick(1);
        chk("R7 all clear", status_word[24:12], 0);
        // Random traffic compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            r = $urandom;
            if (r[3:0] == 0) gp_in = gp_in ^ r[7:4];
            ovl_in  = (r[11:8] == 0) ? r[16:12] : 5'd0;
            rd_done = (r[20:18] == 0);
            ctrl_wr = (r[25:21] == 0);
            ctrl_data = {r[31:26], r[19:0]};
            if (r[30:27] == 0) rst_n = 0; else rst_n = 1;
            tick(1);
        end
        ctrl_wr = 0; rd_done = 0; rst_n = 1;
        tick(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule